// File: doc/BRIEF.md
# Self-Stopping Power-Up Reset Pulse Generator

This block makes one reset pulse for the logic around it, with no reset pin of its own. It relies on flip-flops that take a known value when the device is configured. A small counter starts from zero and advances on every clock edge. The reset output is active while the count is inside a window set by two thresholds. When the count reaches the upper threshold it stops for good, so the pulse never repeats.

The thresholds, the counter width and the active level of the output are parameters. An elaboration check rejects a lower threshold that is not below the upper one, and an upper threshold that the counter cannot hold. The output comes straight from a flip-flop, so downstream reset inputs see no glitches from the compare logic.

Top module: `por_pulse_gen`

## Requirements
- R1: Before the first clock edge after power-up the internal count is 0 and `rst_o` is at its inactive level. The block has no reset input.
- R2: After clock edge number k (counting from 1), the count equals k until it reaches `WIN_END`.
- R3: `rst_o` becomes active just after edge number `WIN_START`. It stays active for exactly `WIN_END - WIN_START` consecutive cycles and goes inactive just after edge number `WIN_END`.
- R4: Once the count equals `WIN_END` it never changes again, and `rst_o` stays inactive for the rest of operation.
- R5: With `ACT_HIGH = 1` the active level of `rst_o` is 1 and the inactive level is 0. With `ACT_HIGH = 0` the active level is 0 and the inactive level is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that advances the power-up counter |
| rst_o | output | 1 | Registered reset pulse; its active level is set by `ACT_HIGH` |

## Verification
A wrong count, such as a missed increment, a counter that does not stop, or a wrong starting value, moves the pulse edges. It shows at `rst_o` at the first edge of the window that is affected: the pulse starts or ends a cycle early or late, or the pulse comes again after the counter wraps. A polarity fault shows before the first clock edge, because the idle level is then wrong. The bench compares `rst_o` with a per-cycle expected level for two parameter sets well past the window. A counter that fails to stop with 4 bits would wrap in 16 cycles, so it is caught.

// File: rtl/por_pulse_gen.sv
module por_pulse_gen #(
  parameter int CNT_W     = 4,
  parameter int WIN_START = 2,
  parameter int WIN_END   = 4,
  parameter bit ACT_HIGH  = 1'b1
) (
  input  logic clk,
  output logic rst_o
);
  localparam logic [CNT_W-1:0] START_V = CNT_W'(WIN_START);
  localparam logic [CNT_W-1:0] END_V   = CNT_W'(WIN_END);

  if (WIN_START >= WIN_END || WIN_START < 0 || WIN_END > (2**CNT_W) - 1) begin : g_bad_params
    $error("por_pulse_gen: need 0 <= WIN_START < WIN_END <= 2**CNT_W-1");
  end

  logic [CNT_W-1:0] cnt    = '0;
  logic             active = 1'b0;
  logic [CNT_W-1:0] cnt_nxt;
  logic             done;

  assign done    = (cnt == END_V);
  assign cnt_nxt = done ? cnt : cnt + 1'b1;

  always_ff @(posedge clk) begin
    cnt    <= cnt_nxt;
    active <= (cnt_nxt >= START_V) && (cnt_nxt < END_V);
  end

  assign rst_o = ACT_HIGH ? active : ~active;
endmodule

// File: rtl/por_pulse_gen_chk.sv
module por_pulse_gen_chk #(
  parameter int CNT_W     = 4,
  parameter int WIN_START = 2,
  parameter int WIN_END   = 4,
  parameter bit ACT_HIGH  = 1'b1
) (
  input logic             clk,
  input logic [CNT_W-1:0] cnt,
  input logic             rst_o
);
  logic primed = 1'b0;
  logic on;
  always_ff @(posedge clk) primed <= 1'b1;
  assign on = (rst_o == ACT_HIGH);

  initial begin
    AST_IDLE_AT_POWERUP: assert (cnt == '0 && !on); // R1
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!primed)
    (cnt != CNT_W'(WIN_END)) |=> (cnt == $past(cnt) + 1'b1)); // R2
  AST_PULSE_RISE: assert property (@(posedge clk) disable iff (!primed)
    $rose(on) |-> (cnt == CNT_W'(WIN_START))); // R3
  AST_PULSE_FALL: assert property (@(posedge clk) disable iff (!primed)
    $fell(on) |-> (cnt == CNT_W'(WIN_END))); // R3
  AST_FROZEN: assert property (@(posedge clk) disable iff (!primed)
    (cnt == CNT_W'(WIN_END)) |=> ($stable(cnt) && !on)); // R4
endmodule

bind por_pulse_gen por_pulse_gen_chk #(
  .CNT_W(CNT_W), .WIN_START(WIN_START), .WIN_END(WIN_END), .ACT_HIGH(ACT_HIGH)
) u_chk (.clk(clk), .cnt(cnt), .rst_o(rst_o));

// File: tb/por_pulse_gen_bench.sv
`timescale 1ns/1ps
module por_pulse_gen_bench;
  localparam int NCYC = 300;
  localparam int A_S = 2, A_E = 4;
  localparam int B_S = 5, B_E = 13;

  typedef struct { int k; logic ea; logic eb; } exp_t;

  logic clk = 1'b0;
  logic rst_a, rst_b;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  por_pulse_gen u_por_pulse_gen (.clk(clk), .rst_o(rst_a));
  por_pulse_gen #(.CNT_W(6), .WIN_START(B_S), .WIN_END(B_E), .ACT_HIGH(1'b0))
    u_por_pulse_gen_b (.clk(clk), .rst_o(rst_b));

  function automatic logic in_win(int k, int s, int e);
    int c = (k < e) ? k : e;
    return (c >= s) && (c < e);
  endfunction

  task automatic push_expected(int n);
    for (int k = 0; k <= n; k++) begin
      exp_t it;
      it.k  = k;
      it.ea = in_win(k, A_S, A_E);
      it.eb = ~in_win(k, B_S, B_E);
      sb.push_back(it);
    end
  endtask

  task automatic check(string req, int k, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, k, act, exp);
    end
  endtask

  function automatic string tag(int k, int s, int e);
    if (k == 0) return "R1/R5";
    if (k >= s && k <= e) return "R3";
    if (k > e) return "R4";
    return "R2/R5";
  endfunction

  initial push_expected(NCYC);

  initial begin
    int   a_len = 0, b_len = 0, a_first = -1, b_first = -1;
    exp_t it;
    #1;
    it = sb.pop_front();
    check("R1", it.k, rst_a, it.ea);
    check("R5", it.k, rst_b, it.eb);
    while (sb.size() > 0) begin
      @(negedge clk);
      it = sb.pop_front();
      check(tag(it.k, A_S, A_E), it.k, rst_a, it.ea);
      check(tag(it.k, B_S, B_E), it.k, rst_b, it.eb);
      if (rst_a === 1'b1) begin a_len++; if (a_first < 0) a_first = it.k; end
      if (rst_b === 1'b0) begin b_len++; if (b_first < 0) b_first = it.k; end
    end
    check("R3 len A", 0, 1'(a_len == A_E - A_S), 1'b1);
    check("R3 start A", a_first, 1'(a_first == A_S), 1'b1);
    check("R3 len B", 0, 1'(b_len == B_E - B_S), 1'b1);
    check("R3 start B", b_first, 1'(b_first == B_S), 1'b1);
    check("R4 idle A", NCYC, rst_a, 1'b0);
    check("R5 idle B", NCYC, rst_b, 1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule